// File: doc/BRIEF.md
# Power State Change Handshake Controller

This block sits on the function side of a configuration path. It watches configuration writes that set a function's power-state field. When a write moves a physical or virtual function into D1 or D3hot, the block raises an interrupt toward user logic and shows the number of the function that was written. It also pulls a completion-enable line low, so that no configuration read or write completes until user logic acknowledges. The acknowledge is normally a one-cycle pulse. When it arrives, the new state is committed to the per-function status outputs, the interrupt falls and completions flow again.

Power-state writes enter through a valid/ready stream. A write is accepted on any cycle where both `wr_valid` and `wr_ready` are high. `wr_ready` falls only while a second write is parked in the single-entry holding slot behind an outstanding interrupt, and rises again when that slot is drained by an acknowledge. A source must hold `wr_func` and `wr_state` stable while `wr_valid` is high and `wr_ready` is low. Writes that need no handshake take effect at once. User logic that never needs to delay completions can tie the acknowledge high.

Top module: `pm_state_handshake`

## Requirements
- R1: After reset every function's status is D0 (code 00), `pm_irq` is 0, `cpl_en` is 1 and `wr_ready` is 1.
- R2: An accepted write that sets a function to D1 (01) or D3hot (11), while that function is in a different state, raises `pm_irq` on the following clock edge. `pm_irq_func` then carries the written function number, and the status output for that function keeps its old value.
- R3: Once high, `pm_irq` stays high until `pm_ack` is sampled high, and `cpl_en` is 0 whenever `pm_irq` is 1.
- R4: At the edge where `pm_ack` is sampled high with `pm_irq` high, the pending state is written to the function's status, `pm_irq` falls and `cpl_en` returns to 1. While `pm_irq` is high and `pm_ack` is low, no status field changes.
- R5: An accepted write to D0 (00) or D2 (10), or one that leaves the function's state unchanged, updates the status on the next edge and does not raise `pm_irq`.
- R6: Function numbers 0 to NUM_PF-1 are physical functions, and function p has bits [2p+1:2p] of `pf_pwr_state`. Function numbers NUM_PF to NUM_PF+NUM_VF-1 are virtual functions, and function NUM_PF+v has bits [2v+1:2v] of `vf_pwr_state`. The state codes are 00=D0, 01=D1, 10=D2, 11=D3hot.
- R7: A write whose function number is NUM_PF+NUM_VF or higher is accepted and has no effect on any status output or on `pm_irq`.
- R8: A write accepted while `pm_irq` is high is held in a single-entry slot, and `wr_ready` is 0 while the slot is full. On the acknowledge, the held write is processed as if it had just arrived.
- R9: When `pm_ack` and a new accepted write fall in the same cycle as an outstanding interrupt, the acknowledge is applied first. The new write is then handled against the updated states and may raise a fresh interrupt at once.
- R10: If `pm_ack` is high while no interrupt is outstanding, a D1 or D3hot write taken in that cycle commits on the next edge without raising `pm_irq`. Holding `pm_ack` high therefore never delays completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Power-state write request valid |
| wr_ready | output | 1 | Block can accept a write |
| wr_func | input | 8 | Target function number |
| wr_state | input | 2 | Requested power state code |
| pm_ack | input | 1 | User acknowledge of the power-state interrupt |
| pm_irq | output | 1 | Power-state change interrupt toward user logic |
| pm_irq_func | output | 8 | Function number behind the current interrupt |
| cpl_en | output | 1 | Configuration completions may be returned |
| pf_pwr_state | output | 2*NUM_PF | Physical function power states, 2 bits each |
| vf_pwr_state | output | 2*NUM_VF | Virtual function power states, 2 bits each |

## Verification
The hardest case to reach is the collision where an acknowledge, a full holding slot and a fresh request all meet while an interrupt is pending. The queued write must surface as a new interrupt, and the incoming one must be back-pressured. The bench gets there by raising an interrupt, pushing a second qualifying write into the slot, and then presenting a third write together with the acknowledge. It also drives acknowledge and write in one cycle with the slot empty, and runs a sweep over every function and state transition against a bench-side state model.

// File: rtl/pm_hs_pkg.sv
package pm_hs_pkg;
  localparam int FN_W = 8;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_t;

  typedef struct packed {
    logic [FN_W-1:0] func;
    pstate_t         state;
  } pm_req_t;
endpackage

// File: rtl/pm_req_slot.sv
module pm_req_slot
  import pm_hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  pm_req_t push_req,
  input  logic    pop,
  output logic    full,
  output pm_req_t held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else begin
      if (push) begin
        full <= 1'b1;
        held <= push_req;
      end else if (pop) begin
        full <= 1'b0;
      end
    end
  end

  // R8: the slot never takes a second entry while occupied
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |-> !push);
endmodule

// File: rtl/pm_state_bank.sv
module pm_state_bank #(
  parameter int NUM_FN = 12,
  parameter int IDX_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_en,
  input  logic [IDX_W-1:0]    a_idx,
  input  logic [1:0]          a_state,
  input  logic                b_en,
  input  logic [IDX_W-1:0]    b_idx,
  input  logic [1:0]          b_state,
  output logic [2*NUM_FN-1:0] states
);
  for (genvar i = 0; i < NUM_FN; i++) begin : g_fn
    logic [1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 2'b00;
      else if (b_en && b_idx == IDX_W'(i)) q <= b_state;
      else if (a_en && a_idx == IDX_W'(i)) q <= a_state;
    end
    assign states[2*i +: 2] = q;
  end

  // R5: without a write port active, the stored states stay put
  p_quiet_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en && !b_en |=> $stable(states));
endmodule

// File: rtl/pm_state_handshake.sv
module pm_state_handshake
  import pm_hs_pkg::*;
#(
  parameter int NUM_PF = 4,
  parameter int NUM_VF = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [7:0]          wr_func,
  input  logic [1:0]          wr_state,
  input  logic                pm_ack,
  output logic                pm_irq,
  output logic [7:0]          pm_irq_func,
  output logic                cpl_en,
  output logic [2*NUM_PF-1:0] pf_pwr_state,
  output logic [2*NUM_VF-1:0] vf_pwr_state
);
  localparam int NUM_FN = NUM_PF + NUM_VF;

  logic              irq_q;
  pm_req_t           pend_q;
  logic              slot_full, slot_push, slot_pop;
  pm_req_t           slot_req, in_req, take_req;
  logic              wr_fire, ack_fire, free_now, take_v;
  logic              fn_ok, qual, raise, commit_now;
  logic [1:0]        cur_state;
  logic [2*NUM_FN-1:0] states;

  assign in_req   = '{func: wr_func, state: pstate_t'(wr_state)};
  assign wr_ready = !slot_full;
  assign wr_fire  = wr_valid && wr_ready;
  assign ack_fire = irq_q && pm_ack;
  assign free_now = !irq_q || ack_fire;

  assign slot_pop  = slot_full && ack_fire;
  assign slot_push = wr_fire && !free_now;
  assign take_v    = slot_pop || (wr_fire && free_now);
  assign take_req  = slot_full ? slot_req : in_req;

  always_comb begin
    cur_state = 2'b00;
    for (int i = 0; i < NUM_FN; i++)
      if (take_req.func == FN_W'(i)) cur_state = states[2*i +: 2];
    if (ack_fire && pend_q.func == take_req.func) cur_state = pend_q.state;
  end

  assign fn_ok      = 32'(take_req.func) < NUM_FN;
  assign qual       = fn_ok && (take_req.state == PS_D1 || take_req.state == PS_D3)
                      && take_req.state != pstate_t'(cur_state);
  assign raise      = take_v && qual && !(pm_ack && !irq_q);
  assign commit_now = take_v && fn_ok && !raise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      pend_q <= '0;
    end else begin
      if (raise) begin
        irq_q  <= 1'b1;
        pend_q <= take_req;
      end else if (ack_fire) begin
        irq_q  <= 1'b0;
      end
    end
  end

  pm_req_slot u_slot (
    .clk(clk), .rst_n(rst_n), .push(slot_push), .push_req(in_req),
    .pop(slot_pop), .full(slot_full), .held(slot_req)
  );

  pm_state_bank #(.NUM_FN(NUM_FN), .IDX_W(FN_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .a_en(ack_fire), .a_idx(pend_q.func), .a_state(pend_q.state),
    .b_en(commit_now), .b_idx(take_req.func), .b_state(take_req.state),
    .states(states)
  );

  assign pm_irq       = irq_q;
  assign pm_irq_func  = pend_q.func;
  assign cpl_en       = !irq_q;
  assign pf_pwr_state = states[2*NUM_PF-1:0];
  assign vf_pwr_state = states[2*NUM_FN-1:2*NUM_PF];

  // R3: interrupt is held until acknowledged
  p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_irq && !pm_ack |=> pm_irq);
  // R2: reported function number is steady while waiting
  p_func_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pm_irq && !pm_ack |=> $stable(pm_irq_func));
  // R4: no status moves while the handshake is open
  p_status_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pm_irq && !pm_ack |=> $stable({pf_pwr_state, vf_pwr_state}));
  // R8: the holding slot is only occupied behind an interrupt
  p_slot_needs_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> pm_irq);
  // R10: acknowledge held with nothing pending never lets an interrupt rise
  p_ack_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_irq && pm_ack |=> !pm_irq);
endmodule

// File: tb/pm_state_handshake_tb.sv
module pm_state_handshake_tb;
  localparam int NUM_PF = 4;
  localparam int NUM_VF = 8;
  localparam int NUM_FN = NUM_PF + NUM_VF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, pm_ack = 1'b0;
  logic [7:0] wr_func = '0;
  logic [1:0] wr_state = '0;
  logic wr_ready, pm_irq, cpl_en;
  logic [7:0] pm_irq_func;
  logic [2*NUM_PF-1:0] pf_pwr_state;
  logic [2*NUM_VF-1:0] vf_pwr_state;

  int n_chk = 0, n_fail = 0;
  logic [1:0] m [NUM_FN];

  always #4 clk = ~clk;

  pm_state_handshake #(.NUM_PF(NUM_PF), .NUM_VF(NUM_VF)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_func(wr_func), .wr_state(wr_state), .pm_ack(pm_ack), .pm_irq(pm_irq),
    .pm_irq_func(pm_irq_func), .cpl_en(cpl_en),
    .pf_pwr_state(pf_pwr_state), .vf_pwr_state(vf_pwr_state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_status(input string tag);
    for (int i = 0; i < NUM_FN; i++) begin
      int a;
      a = (i < NUM_PF) ? int'(pf_pwr_state[2*i +: 2])
                       : int'(vf_pwr_state[2*(i-NUM_PF) +: 2]);
      chk(a == int'(m[i]), $sformatf("%s status fn%0d", tag, i), a, int'(m[i]));
    end
  endtask

  task automatic wr(input int f, input int s);
    @(negedge clk);
    wr_valid = 1'b1; wr_func = 8'(f); wr_state = 2'(s);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic ackp();
    @(negedge clk); pm_ack = 1'b1;
    @(negedge clk); pm_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seq [8] = '{1, 1, 3, 3, 2, 1, 0, 0};
    for (int i = 0; i < NUM_FN; i++) m[i] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pm_irq == 0, "R1 irq", pm_irq, 0);
    chk(cpl_en == 1, "R1 cpl_en", cpl_en, 1);
    chk(wr_ready == 1, "R1 wr_ready", wr_ready, 1);
    chk_status("R1");

    // Sweep: R2 R3 R4 R5 R6 R7
    for (int k = 0; k <= NUM_FN + 1; k++) begin
      int f;
      f = (k < NUM_FN) ? k : (k == NUM_FN ? NUM_FN : 200);
      for (int j = 0; j < 8; j++) begin
        int s;
        bit valid, q;
        s = seq[j];
        valid = f < NUM_FN;
        q = valid && (s == 1 || s == 3) && (2'(s) != m[valid ? f : 0]);
        wr(f, s);
        if (q) begin
          chk(pm_irq == 1, "R2 irq rise", pm_irq, 1);
          chk(int'(pm_irq_func) == f, "R2 irq func", pm_irq_func, f);
          chk(cpl_en == 0, "R3 cpl held", cpl_en, 0);
          chk_status("R2 unchanged");
          repeat (3) @(negedge clk);
          chk(pm_irq == 1, "R3 irq hold", pm_irq, 1);
          chk_status("R4 frozen");
          ackp();
          m[f] = 2'(s);
          chk(pm_irq == 0, "R4 irq fall", pm_irq, 0);
          chk(cpl_en == 1, "R4 cpl back", cpl_en, 1);
          chk_status("R4 R6 commit");
        end else begin
          if (valid) m[f] = 2'(s);
          chk(pm_irq == 0, valid ? "R5 no irq" : "R7 no irq", pm_irq, 0);
          chk_status(valid ? "R5 R6 immediate" : "R7 ignored");
        end
      end
    end

    // R8: queued second write
    for (int i = 0; i < NUM_FN; i++) m[i] = 2'b00;
    for (int i = 0; i < NUM_FN; i++) wr(i, 0);
    wr(0, 3);
    chk(pm_irq == 1 && pm_irq_func == 0, "R8 first irq", pm_irq_func, 0);
    wr(1, 1);
    chk(wr_ready == 0, "R8 slot full", wr_ready, 0);
    chk(int'(pm_irq_func) == 0, "R8 func kept", pm_irq_func, 0);
    ackp();
    m[0] = 2'b11;
    chk(pm_irq == 1, "R8 queued irq", pm_irq, 1);
    chk(int'(pm_irq_func) == 1, "R8 queued func", pm_irq_func, 1);
    chk(wr_ready == 1, "R8 slot drained", wr_ready, 1);
    chk_status("R8 first commit");
    ackp();
    m[1] = 2'b01;
    chk(pm_irq == 0, "R8 done", pm_irq, 0);
    chk_status("R8 second commit");

    // R9: ack and new write together, slot empty
    wr(2, 3);
    chk(pm_irq == 1, "R9 setup", pm_irq, 1);
    @(negedge clk);
    pm_ack = 1'b1; wr_valid = 1'b1; wr_func = 8'd3; wr_state = 2'd1;
    @(negedge clk);
    pm_ack = 1'b0; wr_valid = 1'b0;
    m[2] = 2'b11;
    chk(pm_irq == 1, "R9 new irq", pm_irq, 1);
    chk(int'(pm_irq_func) == 3, "R9 new func", pm_irq_func, 3);
    chk_status("R9 ack first");
    // R9 with slot full: slot drains, incoming write is back-pressured
    wr(4, 1);
    chk(wr_ready == 0, "R9 slot full", wr_ready, 0);
    @(negedge clk);
    pm_ack = 1'b1; wr_valid = 1'b1; wr_func = 8'd5; wr_state = 2'd3;
    @(negedge clk);
    pm_ack = 1'b0;
    m[3] = 2'b01;
    chk(int'(pm_irq_func) == 4, "R9 slot first", pm_irq_func, 4);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(wr_ready == 0, "R9 incoming queued", wr_ready, 0);
    ackp();
    m[4] = 2'b01;
    chk(int'(pm_irq_func) == 5 && pm_irq, "R9 incoming irq", pm_irq_func, 5);
    ackp();
    m[5] = 2'b11;
    chk(pm_irq == 0, "R9 drained", pm_irq, 0);
    chk_status("R9 final");

    // R10: acknowledge held high
    @(negedge clk); pm_ack = 1'b1;
    wr(6, 3);
    m[6] = 2'b11;
    chk(pm_irq == 0, "R10 no irq", pm_irq, 0);
    chk(cpl_en == 1, "R10 cpl", cpl_en, 1);
    wr(NUM_FN - 1, 1);
    m[NUM_FN-1] = 2'b01;
    chk(pm_irq == 0, "R10 no irq vf", pm_irq, 0);
    chk_status("R10 immediate");
    @(negedge clk); pm_ack = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule